// File: doc/BRIEF.md
# Binary-to-Residue Forward Converter

This block maps a wide unsigned binary word onto its residue for a single modulus of the form 2^n + k or 2^n − k. It holds no lookup tables. The input word is cut into j slices of n bits, with slice 0 at the least significant end. Each slice is multiplied by a constant: its positional weight 2^(i·n), reduced modulo the modulus. Because 2^n is congruent to −k for the plus form and to +k for the minus form, each constant is a power of ∓k reduced modulo m. All constants are computed at elaboration.

Each scaled slice is brought into [0, m−1] by a fixed chain of conditional subtractions. A balanced tree of modular adders then sums the slices into one fully reduced residue, and a register catches that residue. The handshake is a single valid bit. A word presented with `inVld` high gives its residue with `outVld` high one clock later. Between results the output holds its last value, so a downstream residue channel can sample it at leisure.

Top module: `binResidue`

## Requirements
- R1: With `PLUS_MODE` = 1 the modulus is 2^N_BITS + K_OFF, and every result equals `inData` taken modulo that value.
- R2: With `PLUS_MODE` = 0 the modulus is 2^N_BITS − K_OFF, and every result equals `inData` taken modulo that value.
- R3: Whenever `outVld` is high, `residue` is strictly below the modulus.
- R4: `outVld` in the cycle after a clock edge equals the `inVld` sampled at that edge. Each accepted word gives exactly one result.
- R5: After an edge at which `inVld` is low, `residue` keeps its previous value.
- R6: While `rstN` is low, `outVld` is 0 and `residue` is 0.
- R7: The input width is NUM_CHUNKS·N_BITS, and both 4-slice and 8-slice configurations give correct residues.
- R8: The corner inputs give correct residues: all zeros, all ones, the modulus itself, the modulus minus one, and the largest multiple of the modulus that fits the input width (which must give 0).
- R9: Words presented on consecutive cycles each give their own correct result on consecutive cycles, with no stall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inVld | input | 1 | The word on `inData` is to be converted |
| inData | input | NUM_CHUNKS*N_BITS | Unsigned binary word |
| outVld | output | 1 | `residue` holds the result for the word accepted one cycle earlier |
| residue | output | N_BITS+1 | Fully reduced residue |

## Verification
The bound checker tests the cycle-level contract on every clock edge. It checks that each result equals the previous cycle's word modulo m, that a valid result stays below the modulus, that the valid bit follows the input with a delay of exactly one cycle, that the output holds while idle, and that the outputs are zero under reset. Some behaviour only the bench's scenarios can show. These are the corner values that drive the reduction chains to their extremes: all ones, exact multiples of m, and m−1. They also include an unbroken burst of back-to-back words, and the agreement between a plus-form 4-slice instance and a minus-form 8-slice instance and a reference remainder computed separately.

// File: rtl/binResiduePkg.sv
package binResiduePkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadResidue;
  } ctlStrobeT;

  function automatic longint modulusOf(int nBits, int kOff, bit plusMode);
    longint base;
    base = longint'(1) << nBits;
    return plusMode ? base + kOff : base - kOff;
  endfunction

  // Weight of slice idx: (2^n)^idx mod m, with 2^n replaced by its congruent value
  function automatic longint chunkWeight(int nBits, int kOff, bit plusMode, int idx);
    longint m;
    longint step;
    longint w;
    m    = modulusOf(nBits, kOff, plusMode);
    step = plusMode ? m - kOff : longint'(kOff);
    w    = 1 % m;
    for (int i = 0; i < idx; i++) begin
      w = (w * step) % m;
    end
    return w;
  endfunction

endpackage

// File: rtl/chunkScale.sv
module chunkScale #(
  parameter int     N_BITS = 8,
  parameter longint MODV   = 259,
  parameter longint WEIGHT = 1
) (
  input  logic [N_BITS-1:0] chunk,
  output logic [N_BITS:0]   scaled
);
  localparam int RW = N_BITS + 1;
  localparam int PW = N_BITS + RW;
  localparam logic [PW-1:0] MODP = PW'(MODV);
  localparam logic [PW-1:0] WP   = PW'(WEIGHT);

  logic [PW-1:0] prod;
  logic [PW-1:0] acc;

  assign prod = PW'(chunk) * WP;

  // Restoring remainder against shifted copies of the constant modulus
  always_comb begin
    acc = prod;
    for (int s = N_BITS; s >= 0; s--) begin
      if (acc >= (MODP << s)) begin
        acc = acc - (MODP << s);
      end
    end
  end

  assign scaled = acc[RW-1:0];
endmodule

// File: rtl/modAdd.sv
module modAdd #(
  parameter int     RW   = 9,
  parameter longint MODV = 259
) (
  input  logic [RW-1:0] a,
  input  logic [RW-1:0] b,
  output logic [RW-1:0] sum
);
  localparam logic [RW:0] MODS = (RW+1)'(MODV);

  logic [RW:0] raw;
  logic [RW:0] less;

  assign raw  = {1'b0, a} + {1'b0, b};
  assign less = raw - MODS;
  assign sum  = (raw >= MODS) ? less[RW-1:0] : raw[RW-1:0];
endmodule

// File: rtl/binResidueCtrl.sv
module binResidueCtrl
  import binResiduePkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inVld,
  output ctlStrobeT strobe,
  output logic      outVld
);
  always_comb begin
    strobe.loadResidue = inVld;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outVld <= 1'b0;
    end else begin
      outVld <= inVld;
    end
  end
endmodule

// File: rtl/binResidueDatapath.sv
module binResidueDatapath
  import binResiduePkg::*;
#(
  parameter int N_BITS     = 8,
  parameter int K_OFF      = 3,
  parameter int NUM_CHUNKS = 4,
  parameter bit PLUS_MODE  = 1'b1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  ctlStrobeT                    strobe,
  input  logic [NUM_CHUNKS*N_BITS-1:0] inData,
  output logic [N_BITS:0]              residue
);
  localparam int     RW     = N_BITS + 1;
  localparam longint MODV   = modulusOf(N_BITS, K_OFF, PLUS_MODE);
  localparam int     LEVELS = $clog2(NUM_CHUNKS);
  localparam int     LEAVES = 1 << LEVELS;

  // Heap-ordered tree: node 0 is the root, leaves start at LEAVES-1
  logic [RW-1:0] node [2*LEAVES-1];

  genvar g;
  generate
    for (g = 0; g < LEAVES; g++) begin : gLeaf
      if (g < NUM_CHUNKS) begin : gScale
        chunkScale #(
          .N_BITS(N_BITS),
          .MODV  (MODV),
          .WEIGHT(chunkWeight(N_BITS, K_OFF, PLUS_MODE, g))
        ) uScale (
          .chunk (inData[g*N_BITS +: N_BITS]),
          .scaled(node[LEAVES-1+g])
        );
      end else begin : gPad
        assign node[LEAVES-1+g] = '0;
      end
    end

    for (g = 0; g < LEAVES-1; g++) begin : gAdd
      modAdd #(
        .RW  (RW),
        .MODV(MODV)
      ) uAdd (
        .a  (node[2*g+1]),
        .b  (node[2*g+2]),
        .sum(node[g])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      residue <= '0;
    end else if (strobe.loadResidue) begin
      residue <= node[0];
    end
  end
endmodule

// File: rtl/binResidue.sv
module binResidue
  import binResiduePkg::*;
#(
  parameter int N_BITS     = 8,
  parameter int K_OFF      = 3,
  parameter int NUM_CHUNKS = 4,
  parameter bit PLUS_MODE  = 1'b1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         inVld,
  input  logic [NUM_CHUNKS*N_BITS-1:0] inData,
  output logic                         outVld,
  output logic [N_BITS:0]              residue
);
  ctlStrobeT strobe;

  binResidueCtrl uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .inVld (inVld),
    .strobe(strobe),
    .outVld(outVld)
  );

  binResidueDatapath #(
    .N_BITS    (N_BITS),
    .K_OFF     (K_OFF),
    .NUM_CHUNKS(NUM_CHUNKS),
    .PLUS_MODE (PLUS_MODE)
  ) uDatapath (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .inData (inData),
    .residue(residue)
  );
endmodule

// File: rtl/binResidueChk.sv
module binResidueChk
  import binResiduePkg::*;
#(
  parameter int N_BITS     = 8,
  parameter int K_OFF      = 3,
  parameter int NUM_CHUNKS = 4,
  parameter bit PLUS_MODE  = 1'b1
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         inVld,
  input logic [NUM_CHUNKS*N_BITS-1:0] inData,
  input logic                         outVld,
  input logic [N_BITS:0]              residue
);
  localparam int     RW   = N_BITS + 1;
  localparam longint MODL = modulusOf(N_BITS, K_OFF, PLUS_MODE);

  // R1 and R2: the result is the previous word modulo m
  assert_value_R1: assert property (@(posedge clk) disable iff (!rstN)
    inVld |=> (residue == RW'(longint'($past(inData)) % MODL)));

  assert_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    outVld |-> (longint'(residue) < MODL));

  assert_latency_R4: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (outVld == $past(inVld)));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !inVld |=> $stable(residue));

  assert_reset_R6: assert property (@(posedge clk)
    !rstN |-> (!outVld && residue == '0));
endmodule

bind binResidue binResidueChk #(
  .N_BITS    (N_BITS),
  .K_OFF     (K_OFF),
  .NUM_CHUNKS(NUM_CHUNKS),
  .PLUS_MODE (PLUS_MODE)
) uChk (
  .clk    (clk),
  .rstN   (rstN),
  .inVld  (inVld),
  .inData (inData),
  .outVld (outVld),
  .residue(residue)
);

// File: tb/test_binResidue.sv
module test_binResidue;
  localparam longint M_A = 259;  // 2^8 + 3, 4 slices, 32-bit input
  localparam longint M_B = 59;   // 2^6 - 5, 8 slices, 48-bit input

  typedef struct {
    longint exp;
    string  tag;
  } itemT;

  logic        clk   = 1'b0;
  logic        rstN  = 1'b0;
  logic        inVld = 1'b0;
  logic [47:0] stim  = '0;
  logic        outVldA, outVldB;
  logic [8:0]  resA;
  logic [6:0]  resB;

  int   nChecks = 0;
  int   nFail   = 0;
  itemT qA[$];
  itemT qB[$];
  bit   seenA = 0, seenB = 0;
  logic [8:0] lastA = '0;
  logic [6:0] lastB = '0;

  binResidue #(.N_BITS(8), .K_OFF(3), .NUM_CHUNKS(4), .PLUS_MODE(1'b1)) i_binResidue (
    .clk(clk), .rstN(rstN), .inVld(inVld), .inData(stim[31:0]),
    .outVld(outVldA), .residue(resA)
  );

  binResidue #(.N_BITS(6), .K_OFF(5), .NUM_CHUNKS(8), .PLUS_MODE(1'b0)) i_binResidueMinus (
    .clk(clk), .rstN(rstN), .inVld(inVld), .inData(stim),
    .outVld(outVldB), .residue(resB)
  );

  always #5 clk = ~clk;

  task automatic check(bit ok, string req, longint act, longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(logic [47:0] v, string tagA, string tagB);
    itemT a, b;
    @(negedge clk);
    stim  = v;
    inVld = 1'b1;
    a.exp = longint'(v[31:0]) % M_A;
    a.tag = tagA;
    b.exp = longint'(v) % M_B;
    b.tag = tagB;
    qA.push_back(a);
    qB.push_back(b);
  endtask

  task automatic idle(int cycles);
    @(negedge clk);
    inVld = 1'b0;
    repeat (cycles - 1) @(negedge clk);
  endtask

  // Monitor: sample shortly after each rising edge
  always begin
    itemT it;
    @(posedge clk);
    #2;
    if (rstN) begin
      if (outVldA) begin
        if (qA.size() == 0) check(1'b0, "R4 plus unexpected valid", 1, 0);
        else begin
          it = qA.pop_front();
          check(resA == 9'(it.exp), {it.tag, " plus residue"}, longint'(resA), it.exp);
          check(longint'(resA) < M_A, "R3 plus range", longint'(resA), M_A - 1);
          lastA = resA;
          seenA = 1;
        end
      end else begin
        if (qA.size() != 0) check(1'b0, "R4 plus missing valid", 0, 1);
        if (seenA) check(resA == lastA, "R5 plus hold", longint'(resA), longint'(lastA));
      end
      if (outVldB) begin
        if (qB.size() == 0) check(1'b0, "R4 minus unexpected valid", 1, 0);
        else begin
          it = qB.pop_front();
          check(resB == 7'(it.exp), {it.tag, " minus residue"}, longint'(resB), it.exp);
          check(longint'(resB) < M_B, "R3 minus range", longint'(resB), M_B - 1);
          lastB = resB;
          seenB = 1;
        end
      end else begin
        if (qB.size() != 0) check(1'b0, "R4 minus missing valid", 0, 1);
        if (seenB) check(resB == lastB, "R5 minus hold", longint'(resB), longint'(lastB));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    longint bigA, bigB;
    bigA = ((longint'(1) << 32) - 1) / M_A * M_A;
    bigB = ((longint'(1) << 48) - 1) / M_B * M_B;

    // R6: reset state
    repeat (3) @(negedge clk);
    check(!outVldA && resA == '0, "R6 plus reset", longint'(resA), 0);
    check(!outVldB && resB == '0, "R6 minus reset", longint'(resB), 0);
    @(negedge clk);
    rstN = 1'b1;
    idle(2);

    // R8 corner values, R7 covered by the 8-slice instance
    drive(48'h0, "R8", "R8 R7");
    drive(48'hFFFF_FFFF_FFFF, "R8", "R8 R7");
    drive(48'(M_A), "R8", "R8 R7");
    drive(48'(M_A - 1), "R8", "R8 R7");
    drive(48'(M_B), "R8", "R8 R7");
    drive(48'(M_B - 1), "R8", "R8 R7");
    drive(48'(bigA), "R8", "R8 R7");
    drive(48'(bigB), "R8", "R8 R7");
    drive(48'(M_A * M_B * 1000003), "R8", "R8 R7");
    idle(4);

    // R1, R2, R9: unbroken burst of random words
    for (int i = 0; i < 150; i++) begin
      drive({16'($urandom), 32'($urandom)}, "R1 R9", "R2 R7 R9");
    end
    idle(3);

    // Sparse words with idle gaps between them
    for (int i = 0; i < 30; i++) begin
      drive({16'($urandom), 32'($urandom)}, "R1", "R2");
      idle(1 + (i % 3));
    end
    idle(3);

    check(qA.size() == 0 && qB.size() == 0, "R4 all results delivered",
          longint'(qA.size() + qB.size()), 0);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule